// File: doc/BRIEF.md
# Programmable Down-Counter / Square-Wave Timer with Output Pin

This block is a down-counter of parameterised width (16 bits by default) that advances only on cycles where a clock-enable tick is high. The mode is chosen when the counter starts. In one-shot counter mode it counts a programmed number of ticks once, pulls its output pin low when it reaches terminal count, and holds the pin low until a stop command arrives. In timer mode it reloads itself at every terminal count and toggles the pin, so the pin carries a square wave whose period is twice the programmed count.

A start command captures the preload value and the mode, then arms the counter. A stop command halts counting, returns the pin high and clears the terminal-count flag. The pin is not gated by any interrupt mask. Its level is driven straight from the counter state. A preload of zero stands for the full range of 2^WIDTH ticks.

Top module: `cnt_tmr`

## Requirements
- R1: After reset the pin is high (1), the terminal-count flag is low (0) and no counting takes place until a start command.
- R2: A start command captures the preload value. Only ticks in later cycles count, so a tick in the same cycle as start is ignored. Cycles without a tick leave the count unchanged.
- R3: Timer mode (mode input = 1 at start): after every N counted ticks (N = captured preload) the pin toggles and the count reloads from N, so the pin has a period of 2N ticks.
- R4: Counter mode (mode input = 0 at start): the pin stays high for the first N-1 counted ticks and goes low on tick N. Counting then halts, and further ticks leave the pin low.
- R5: A stop command drives the pin high, clears the flag and halts counting from the next cycle. Stop takes priority over a start in the same cycle.
- R6: The terminal-count flag sets at the first terminal count in either mode and stays set until a stop command.
- R7: A preload of 0 counts 2^WIDTH ticks to terminal count.
- R8: Changes on the mode and preload inputs after a start have no effect until the next start.
- R9: A start while counting restarts the count from the preload value and leaves the pin level and the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable, one count per high cycle |
| preload | input | WIDTH | Count length; 0 means 2^WIDTH |
| mode | input | 1 | 1 = timer (square wave), 0 = one-shot counter |
| start_cmd | input | 1 | Capture preload and mode, arm counter |
| stop_cmd | input | 1 | Halt, pin high, clear flag |
| pin_out | output | 1 | Output pin level |
| tc_flag | output | 1 | Terminal count has been reached since last stop |

## Verification
The hardest state to reach from the ports is the full-range count for a zero preload. The stimulus holds tick high for 65535 cycles, checks that the pin is still high, and then checks that it falls on the next tick. Other hard-to-reach cases are a start that lands on a cycle with a tick, a restart mid-count after the pin has already toggled, and a stop that coincides with a start. Each of these is driven directly by its own task, with exact tick counts, so the expected pin edge falls on a known cycle.

// File: rtl/cnt_tmr_pkg.sv
package cnt_tmr_pkg;
   typedef enum logic {
      MODE_COUNTER = 1'b0,
      MODE_TIMER   = 1'b1
   } ct_mode_e;
endpackage

// File: rtl/cnt_tmr_reload.sv
module cnt_tmr_reload #(
   parameter int WIDTH    = 16,
   parameter bit ZERO_MAX = 1'b1,
   localparam int CW      = WIDTH + 1
) (
   input  logic [WIDTH-1:0] preload,
   output logic [CW-1:0]    load_val
);
   generate
      if (ZERO_MAX) begin : g_zero_full
         always_comb begin
            if (preload == '0) load_val = {1'b1, {WIDTH{1'b0}}};
            else               load_val = {1'b0, preload};
         end
      end else begin : g_zero_one
         always_comb begin
            if (preload == '0) load_val = CW'(1);
            else               load_val = {1'b0, preload};
         end
      end
   endgenerate
endmodule

// File: rtl/cnt_tmr_down.sv
module cnt_tmr_down #(
   parameter int WIDTH = 16,
   localparam int CW   = WIDTH + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          step,
   input  logic          rearm,
   output logic          hit,
   output logic [CW-1:0] cnt
);
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] rl_q;

   assign hit = step && (cnt_q == CW'(1));
   assign cnt = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         rl_q  <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
         rl_q  <= load_val;
      end else if (step) begin
         if (cnt_q == CW'(1)) cnt_q <= rearm ? rl_q : '0;
         else                 cnt_q <= cnt_q - CW'(1);
      end
   end

   // R2: a counting step never sees an empty counter
   assert_step_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> (cnt_q != '0));

   // R2: idle cycles hold the count
   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !load && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/cnt_tmr_ctl.sv
module cnt_tmr_ctl
   import cnt_tmr_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic mode,
   input  logic start_cmd,
   input  logic stop_cmd,
   input  logic hit,
   output logic step,
   output logic load,
   output logic rearm,
   output logic pin,
   output logic tc
);
   logic     run_q;
   ct_mode_e mode_q;
   logic     pin_q;
   logic     tc_q;

   assign load  = start_cmd && !stop_cmd;
   assign step  = tick && run_q && !start_cmd && !stop_cmd;
   assign rearm = (mode_q == MODE_TIMER);
   assign pin   = pin_q;
   assign tc    = tc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         mode_q <= MODE_COUNTER;
         pin_q  <= 1'b1;
         tc_q   <= 1'b0;
      end else if (stop_cmd) begin
         run_q <= 1'b0;
         pin_q <= 1'b1;
         tc_q  <= 1'b0;
      end else if (start_cmd) begin
         run_q  <= 1'b1;
         mode_q <= ct_mode_e'(mode);
      end else if (hit) begin
         tc_q <= 1'b1;
         if (mode_q == MODE_TIMER) begin
            pin_q <= ~pin_q;
         end else begin
            pin_q <= 1'b0;
            run_q <= 1'b0;
         end
      end
   end

   // R5: stop returns pin high and clears the flag
   assert_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      stop_cmd |=> (pin_q && !tc_q));

   // R6: flag only rises on a terminal count
   assert_tc_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tc_q) |-> $past(hit));

   // R4: one-shot halts after terminal count
   assert_oneshot_halt_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && mode_q == MODE_COUNTER) |=> (!run_q && !pin_q));

   // R3: timer terminal count toggles the pin
   assert_timer_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && mode_q == MODE_TIMER) |=> (pin_q != $past(pin_q)));
endmodule

// File: rtl/cnt_tmr.sv
module cnt_tmr #(
   parameter int WIDTH    = 16,
   parameter bit ZERO_MAX = 1'b1,
   localparam int CW      = WIDTH + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [WIDTH-1:0] preload,
   input  logic             mode,
   input  logic             start_cmd,
   input  logic             stop_cmd,
   output logic             pin_out,
   output logic             tc_flag
);
   generate
      if (WIDTH < 2 || WIDTH > 32) begin : g_bad_width
         $error("cnt_tmr: WIDTH must be in 2..32");
      end
   endgenerate

   logic [CW-1:0] load_val;
   logic [CW-1:0] cnt;
   logic          step, load, rearm, hit;

   cnt_tmr_reload #(.WIDTH(WIDTH), .ZERO_MAX(ZERO_MAX)) u_reload (
      .preload (preload),
      .load_val(load_val)
   );

   cnt_tmr_ctl u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .mode     (mode),
      .start_cmd(start_cmd),
      .stop_cmd (stop_cmd),
      .hit      (hit),
      .step     (step),
      .load     (load),
      .rearm    (rearm),
      .pin      (pin_out),
      .tc       (tc_flag)
   );

   cnt_tmr_down #(.WIDTH(WIDTH)) u_down (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (stop_cmd),
      .load    (load),
      .load_val(load_val),
      .step    (step),
      .rearm   (rearm),
      .hit     (hit),
      .cnt     (cnt)
   );

   // R6: a low pin always means terminal count was reached
   assert_low_has_tc_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_out |-> tc_flag);

   // R1: outputs idle right after reset release
   assert_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pin_out && !tc_flag));
endmodule

// File: tb/cnt_tmr_tb.sv
module cnt_tmr_tb;
   localparam int CLK_PERIOD = 10;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tick = 1'b0;
   logic [W-1:0] preload = '0;
   logic         mode = 1'b0;
   logic         start_cmd = 1'b0;
   logic         stop_cmd = 1'b0;
   logic         pin_out, tc_flag;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cnt_tmr #(.WIDTH(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .preload(preload), .mode(mode),
      .start_cmd(start_cmd), .stop_cmd(stop_cmd), .pin_out(pin_out), .tc_flag(tc_flag)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%b expected=%b", req, act, exp);
      end
   endtask

   // all drives happen just after a negedge; one call = one clock cycle
   task automatic cyc(input logic t, input logic st, input logic sp);
      @(negedge clk);
      tick = t; start_cmd = st; stop_cmd = sp;
      @(posedge clk);
      #1;
      tick = 1'b0; start_cmd = 1'b0; stop_cmd = 1'b0;
   endtask

   task automatic start(input logic [W-1:0] p, input logic m);
      @(negedge clk);
      preload = p; mode = m;
      cyc(1'b0, 1'b1, 1'b0);
   endtask

   task automatic stop();
      cyc(1'b0, 1'b0, 1'b1);
   endtask

   task automatic t_reset();
      chk("R1 pin", pin_out, 1'b1);
      chk("R1 tc", tc_flag, 1'b0);
      for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, 1'b0);
      chk("R1 idle pin", pin_out, 1'b1);
      chk("R1 idle tc", tc_flag, 1'b0);
   endtask

   task automatic t_oneshot();
      start(16'd5, 1'b0);
      for (int i = 0; i < 4; i++) begin
         cyc(1'b1, 1'b0, 1'b0);
         cyc(1'b0, 1'b0, 1'b0);
      end
      chk("R4 high before tc", pin_out, 1'b1);
      chk("R6 tc before", tc_flag, 1'b0);
      cyc(1'b1, 1'b0, 1'b0);
      chk("R4 low at tc", pin_out, 1'b0);
      chk("R6 tc set", tc_flag, 1'b1);
      for (int i = 0; i < 10; i++) cyc(1'b1, 1'b0, 1'b0);
      chk("R4 stays low", pin_out, 1'b0);
      chk("R6 tc held", tc_flag, 1'b1);
      stop();
      chk("R5 pin high", pin_out, 1'b1);
      chk("R5 tc clear", tc_flag, 1'b0);
   endtask

   task automatic t_start_tick();
      // tick in the start cycle must not count
      @(negedge clk);
      preload = 16'd3; mode = 1'b0;
      cyc(1'b1, 1'b1, 1'b0);
      cyc(1'b1, 1'b0, 1'b0);
      cyc(1'b1, 1'b0, 1'b0);
      chk("R2 start tick ignored", pin_out, 1'b1);
      cyc(1'b1, 1'b0, 1'b0);
      chk("R2 third tick", pin_out, 1'b0);
      stop();
   endtask

   task automatic t_timer();
      logic exp;
      start(16'd3, 1'b1);
      for (int i = 1; i <= 13; i++) begin
         cyc(1'b1, 1'b0, 1'b0);
         if (i % 2 == 0) cyc(1'b0, 1'b0, 1'b0);
         exp = ((i / 3) % 2 == 0);
         chk("R3 square wave", pin_out, exp);
         chk("R6 timer tc", tc_flag, (i >= 3));
      end
      stop();
      chk("R5 timer stop pin", pin_out, 1'b1);
      for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 1'b0);
      chk("R5 halted", pin_out, 1'b1);
      chk("R5 halted tc", tc_flag, 1'b0);
   endtask

   task automatic t_change();
      start(16'd4, 1'b0);
      preload = 16'd2; mode = 1'b1;
      for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b0);
      chk("R8 preload ignored", pin_out, 1'b1);
      cyc(1'b1, 1'b0, 1'b0);
      chk("R8 captured count", pin_out, 1'b0);
      for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 1'b0);
      chk("R8 mode ignored", pin_out, 1'b0);
      stop();
   endtask

   task automatic t_restart();
      start(16'd2, 1'b1);
      cyc(1'b1, 1'b0, 1'b0);
      cyc(1'b1, 1'b0, 1'b0);
      chk("R3 first toggle", pin_out, 1'b0);
      cyc(1'b1, 1'b0, 1'b0);
      start(16'd3, 1'b1);
      chk("R9 pin kept", pin_out, 1'b0);
      chk("R9 tc kept", tc_flag, 1'b1);
      cyc(1'b1, 1'b0, 1'b0);
      cyc(1'b1, 1'b0, 1'b0);
      chk("R9 restarted count", pin_out, 1'b0);
      cyc(1'b1, 1'b0, 1'b0);
      chk("R9 toggle after 3", pin_out, 1'b1);
      stop();
   endtask

   task automatic t_stop_wins();
      start(16'd1, 1'b0);
      cyc(1'b1, 1'b0, 1'b0);
      chk("R4 preload one", pin_out, 1'b0);
      @(negedge clk);
      preload = 16'd1;
      cyc(1'b0, 1'b1, 1'b1);
      chk("R5 stop over start pin", pin_out, 1'b1);
      for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b0);
      chk("R5 not armed", pin_out, 1'b1);
      chk("R5 not armed tc", tc_flag, 1'b0);
   endtask

   task automatic t_zero();
      start(16'd0, 1'b0);
      @(negedge clk);
      tick = 1'b1;
      for (int i = 0; i < 65535; i++) @(posedge clk);
      #1;
      chk("R7 high at 65535", pin_out, 1'b1);
      @(posedge clk);
      #1;
      tick = 1'b0;
      chk("R7 low at 65536", pin_out, 1'b0);
      stop();
   endtask

   initial begin
      #(CLK_PERIOD * 3);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_oneshot();
      t_start_tick();
      t_timer();
      t_change();
      t_restart();
      t_stop_wins();
      t_zero();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            #(CLK_PERIOD * 150000);
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
         end
      join_any
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule